// File: doc/BRIEF.md
# Quadword Pair Store Sequencer

This block stores a 128-bit quantity, held in an even/odd pair of general registers, to memory as two 64-bit write beats. A start strobe brings in the base register value, a flag that says the base field names register zero, a 14-bit word displacement, the contents of both registers of the pair and the endian mode. The block computes the effective address, works out which register goes to which doubleword and whether its bytes are reversed, and then issues the two beats on a valid/ready write port. The lower-addressed beat always goes first.

In big-endian mode the even register lands unchanged at the effective address and the odd register unchanged eight bytes above it. In little-endian mode the roles swap: the odd register, byte-reversed, lands at the effective address and the even register, byte-reversed, eight bytes above. A one-cycle completion pulse follows the second accepted beat. If the source register number is odd, the block flags an invalid form and writes nothing.

Top module: `qsp_store_pair`

## Requirements
- R1: The effective address is the base value plus the displacement sign-extended after two zero bits are appended below it (displacement times four), computed modulo 2^AW.
- R2: When the base-is-zero flag is set, the base value is ignored and the effective address is the scaled, sign-extended displacement alone.
- R3: In big-endian mode (endian bit 0) the first beat carries the even register unchanged at the effective address and the second beat carries the odd register unchanged at the effective address plus 8.
- R4: In little-endian mode (endian bit 1) the first beat carries the odd register byte-reversed at the effective address and the second beat carries the even register byte-reversed at the effective address plus 8; byte reversal moves bits [8k+7:8k] to bits [8(7-k)+7:8(7-k)].
- R5: The first beat is presented in the cycle after start is accepted. While a beat is valid and not ready, valid, address and data stay unchanged, and the second beat appears only after the first has been accepted.
- R6: Done is high for exactly one cycle, in the cycle after the second beat is accepted, and write valid is low in that cycle.
- R7: A start with the source register odd flag set (least significant bit of the register number is 1) raises the invalid-form output for one cycle, in the cycle after start, and produces no write beat.
- R8: While a sequence is in progress, start and all operand inputs are ignored: the beats carry the operands sampled with the accepted start, no invalid-form pulse appears, and no new sequence follows.
- R9: After reset, write valid, done, invalid-form and busy are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pair store; taken only when idle |
| base_val | input | AW | Contents of the base register |
| base_is_zero | input | 1 | Base field names register zero; use 0 as base |
| disp | input | DSW | Word displacement, signed |
| src_reg_odd | input | 1 | Least significant bit of the source register number |
| even_val | input | DW | Even register of the pair |
| odd_val | input | DW | Odd register of the pair |
| little_endian | input | 1 | 1 selects little-endian placement |
| wr_valid | output | 1 | Write beat is valid |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_addr | output | AW | Byte address of the beat |
| wr_data | output | DW | Doubleword of the beat |
| done | output | 1 | One-cycle completion pulse |
| bad_form | output | 1 | One-cycle invalid-form pulse |
| busy | output | 1 | A sequence is in progress |

## Verification
The sweep covers both endian modes, both base-zero settings, displacements at zero, ±1 word and the signed extremes, and a base that makes the second beat wrap past the top of the address space; a design that sign-extends wrongly or forgets the scaling shows a wrong first address, and one that swaps the registers in only one mode or skips the byte reversal shows wrong data. Ready is held low for zero to two cycles on each beat, so a design that advances without acceptance or lets a held beat drift is caught. While a beat waits, the bench pulses start with scrambled operands and an odd register number; a design that re-captures operands, raises the invalid flag, or chains a second sequence shows it in the data or in the cycles after done. Odd register numbers in both modes must give the flag with no write.

// File: rtl/qsp_pkg.sv
package qsp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } qsp_state_e;

    // What a beat carries: which register, whether its bytes are reversed,
    // and whether it sits at the upper doubleword.
    typedef struct packed {
        logic take_odd;
        logic reverse;
        logic upper;
    } qsp_beat_t;

    function automatic qsp_beat_t qsp_plan(input logic le, input logic upper);
        qsp_beat_t p;
        p.upper    = upper;
        p.reverse  = le;
        p.take_odd = upper ^ le;
        return p;
    endfunction

endpackage

// File: rtl/qsp_ea_calc.sv
module qsp_ea_calc #(
    parameter int AW  = 64,
    parameter int DSW = 14
) (
    input  logic [AW-1:0]  base,
    input  logic           base_zero,
    input  logic [DSW-1:0] disp,
    output logic [AW-1:0]  ea
);
    localparam int PADW = AW - DSW - 2;

    logic [AW-1:0] base_eff;
    logic [AW-1:0] offset;

    always_comb begin
        base_eff = base_zero ? '0 : base;
        offset   = {{PADW{disp[DSW-1]}}, disp, 2'b00};
        ea       = base_eff + offset;
    end
endmodule

// File: rtl/qsp_byte_rev.sv
module qsp_byte_rev #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] din,
    input  logic          en,
    output logic [DW-1:0] dout
);
    localparam int NB = DW / 8;

    logic [DW-1:0] swapped;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign swapped[8*g +: 8] = din[8*(NB-1-g) +: 8];
    end

    assign dout = en ? swapped : din;
endmodule

// File: rtl/qsp_seq.sv
module qsp_seq
    import qsp_pkg::*;
#(
    parameter int AW = 64,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          bad_idx,
    input  logic [AW-1:0] ea_in,
    input  logic [DW-1:0] even_in,
    input  logic [DW-1:0] odd_in,
    input  logic          le_in,
    input  logic          wr_ready,
    output qsp_state_e    state,
    output logic [AW-1:0] ea_q,
    output logic [DW-1:0] even_q,
    output logic [DW-1:0] odd_q,
    output logic          le_q,
    output logic          done,
    output logic          bad_form
);
    qsp_state_e nxt;
    logic       take;
    logic       accept;

    always_comb begin
        take   = start && (state == ST_IDLE);
        accept = (state != ST_IDLE) && wr_ready;
        nxt    = state;
        unique case (state)
            ST_IDLE: if (take && !bad_idx) nxt = ST_LOW;
            ST_LOW:  if (accept)           nxt = ST_HIGH;
            ST_HIGH: if (accept)           nxt = ST_IDLE;
            default:                       nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ea_q     <= '0;
            even_q   <= '0;
            odd_q    <= '0;
            le_q     <= 1'b0;
            done     <= 1'b0;
            bad_form <= 1'b0;
        end else begin
            state    <= nxt;
            done     <= (state == ST_HIGH) && accept;
            bad_form <= take && bad_idx;
            if (take && !bad_idx) begin
                ea_q   <= ea_in;
                even_q <= even_in;
                odd_q  <= odd_in;
                le_q   <= le_in;
            end
        end
    end
endmodule

// File: rtl/qsp_store_pair.sv
module qsp_store_pair
    import qsp_pkg::*;
#(
    parameter int AW  = 64,
    parameter int DW  = 64,
    parameter int DSW = 14
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [AW-1:0]  base_val,
    input  logic           base_is_zero,
    input  logic [DSW-1:0] disp,
    input  logic           src_reg_odd,
    input  logic [DW-1:0]  even_val,
    input  logic [DW-1:0]  odd_val,
    input  logic           little_endian,
    output logic           wr_valid,
    input  logic           wr_ready,
    output logic [AW-1:0]  wr_addr,
    output logic [DW-1:0]  wr_data,
    output logic           done,
    output logic           bad_form,
    output logic           busy
);
    localparam int          BEAT_BYTES = DW / 8;
    localparam logic [AW-1:0] UPPER_OFS = AW'(BEAT_BYTES);

    logic [AW-1:0] ea_now;
    logic [AW-1:0] ea_q;
    logic [DW-1:0] even_q;
    logic [DW-1:0] odd_q;
    logic          le_q;
    qsp_state_e    state;
    qsp_beat_t     plan;
    logic [DW-1:0] picked;

    qsp_ea_calc #(.AW(AW), .DSW(DSW)) u_ea (
        .base      (base_val),
        .base_zero (base_is_zero),
        .disp      (disp),
        .ea        (ea_now)
    );

    qsp_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .bad_idx  (src_reg_odd),
        .ea_in    (ea_now),
        .even_in  (even_val),
        .odd_in   (odd_val),
        .le_in    (little_endian),
        .wr_ready (wr_ready),
        .state    (state),
        .ea_q     (ea_q),
        .even_q   (even_q),
        .odd_q    (odd_q),
        .le_q     (le_q),
        .done     (done),
        .bad_form (bad_form)
    );

    always_comb begin
        plan    = qsp_plan(le_q, state == ST_HIGH);
        picked  = plan.take_odd ? odd_q : even_q;
        wr_addr = plan.upper ? (ea_q + UPPER_OFS) : ea_q;
    end

    qsp_byte_rev #(.DW(DW)) u_rev (
        .din  (picked),
        .en   (plan.reverse),
        .dout (wr_data)
    );

    assign wr_valid = (state != ST_IDLE);
    assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/qsp_store_pair_chk.sv
module qsp_store_pair_chk #(
    parameter int AW = 64,
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          done,
    input logic          bad_form
);
    localparam logic [AW-1:0] STEP = AW'(DW / 8);

    logic second;

    always_ff @(posedge clk) begin
        if (rst)                       second <= 1'b0;
        else if (wr_valid && wr_ready) second <= !second;
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && !second) |=> (wr_valid && wr_addr == $past(wr_addr) + STEP));

    p_done_after_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && second) |=> (done && !wr_valid));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_bad_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
        bad_form |-> (!wr_valid && !done));

    p_bad_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        bad_form |=> !bad_form);
endmodule

bind qsp_store_pair qsp_store_pair_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .done     (done),
    .bad_form (bad_form)
);

// File: tb/qsp_store_pair_test.sv
module qsp_store_pair_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 64;
    localparam int DW = 64;
    localparam int DSW = 14;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [AW-1:0]  base_val = '0;
    logic           base_is_zero = 1'b0;
    logic [DSW-1:0] disp = '0;
    logic           src_reg_odd = 1'b0;
    logic [DW-1:0]  even_val = '0;
    logic [DW-1:0]  odd_val = '0;
    logic           little_endian = 1'b0;
    logic           wr_valid;
    logic           wr_ready = 1'b0;
    logic [AW-1:0]  wr_addr;
    logic [DW-1:0]  wr_data;
    logic           done;
    logic           bad_form;
    logic           busy;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic finished = 1'b0;
    logic [63:0] lcg = 64'h1234_5678_9ABC_DEF1;

    always #(CLK_PERIOD/2) clk = ~clk;

    qsp_store_pair #(.AW(AW), .DW(DW), .DSW(DSW)) uut (
        .clk(clk), .rst(rst), .start(start), .base_val(base_val),
        .base_is_zero(base_is_zero), .disp(disp), .src_reg_odd(src_reg_odd),
        .even_val(even_val), .odd_val(odd_val), .little_endian(little_endian),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done), .bad_form(bad_form), .busy(busy)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            n_bad = n_bad + 1;
            n_chk = n_chk + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<=100000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] brev(input logic [63:0] v);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[8*k +: 8] = v[8*(7-k) +: 8];
        return r;
    endfunction

    function automatic logic [63:0] next_rand();
        lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
        return lcg;
    endfunction

    task automatic run_one(input logic [63:0] b, input logic z, input logic [13:0] d,
                           input logic [63:0] ev, input logic [63:0] od, input logic le,
                           input int d0, input int d1);
        logic [63:0] ea;
        logic [63:0] a0, a1, x0, x1;
        ea = (z ? 64'd0 : b) + {{48{d[13]}}, d, 2'b00};
        a0 = ea;
        a1 = ea + 64'd8;
        x0 = le ? brev(od) : ev;
        x1 = le ? brev(ev) : od;
        @(negedge clk);
        base_val = b; base_is_zero = z; disp = d; even_val = ev; odd_val = od;
        little_endian = le; src_reg_odd = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // first beat, possibly held
        for (int w = 0; w < d0; w++) begin
            chk(wr_valid == 1'b1, "R5 first beat valid while held", {63'd0, wr_valid}, 64'd1);
            chk(wr_addr == a0, (z ? "R2 addr held" : "R1 addr held"), wr_addr, a0);
            chk(wr_data == x0, (le ? "R4 data held" : "R3 data held"), wr_data, x0);
            // R8: scrambled start and operands while busy
            start = 1'b1; src_reg_odd = w[0]; base_val = next_rand();
            even_val = next_rand(); odd_val = next_rand(); little_endian = ~le;
            @(negedge clk);
            chk(bad_form == 1'b0, "R8 no bad_form while busy", {63'd0, bad_form}, 64'd0);
        end
        start = 1'b0; src_reg_odd = 1'b0;
        chk(wr_valid == 1'b1, "R5 first beat valid", {63'd0, wr_valid}, 64'd1);
        chk(wr_addr == a0, (z ? "R2 first addr" : "R1 first addr"), wr_addr, a0);
        chk(wr_data == x0, (le ? "R4 first data" : "R3 first data"), wr_data, x0);
        wr_ready = 1'b1;
        @(negedge clk);
        wr_ready = 1'b0;
        for (int w = 0; w < d1; w++) begin
            chk(wr_valid == 1'b1 && wr_addr == a1, "R5 second beat held", wr_addr, a1);
            @(negedge clk);
        end
        chk(wr_valid == 1'b1, "R5 second beat valid", {63'd0, wr_valid}, 64'd1);
        chk(wr_addr == a1, "R3 second addr", wr_addr, a1);
        chk(wr_data == x1, (le ? "R4 second data" : "R3 second data"), wr_data, x1);
        chk(done == 1'b0, "R6 no early done", {63'd0, done}, 64'd0);
        wr_ready = 1'b1;
        @(negedge clk);
        wr_ready = 1'b0;
        chk(done == 1'b1 && wr_valid == 1'b0, "R6 done after second accept",
            {62'd0, done, wr_valid}, 64'd2);
        @(negedge clk);
        chk(done == 1'b0 && wr_valid == 1'b0 && busy == 1'b0, "R8 R6 quiet after done",
            {61'd0, done, wr_valid, busy}, 64'd0);
    endtask

    task automatic run_bad(input logic le);
        @(negedge clk);
        src_reg_odd = 1'b1; little_endian = le; base_val = next_rand(); start = 1'b1;
        @(negedge clk);
        start = 1'b0; src_reg_odd = 1'b0;
        chk(bad_form == 1'b1 && wr_valid == 1'b0, "R7 bad_form raised, no write",
            {62'd0, bad_form, wr_valid}, 64'd2);
        @(negedge clk);
        chk(bad_form == 1'b0 && wr_valid == 1'b0, "R7 bad_form one cycle, no write",
            {62'd0, bad_form, wr_valid}, 64'd0);
    endtask

    initial begin
        logic [13:0] dl [5];
        dl[0] = 14'h0000; dl[1] = 14'h0001; dl[2] = 14'h1FFF;
        dl[3] = 14'h2000; dl[4] = 14'h3FFF;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(wr_valid == 0 && done == 0 && bad_form == 0 && busy == 0, "R9 reset state",
            {60'd0, wr_valid, done, bad_form, busy}, 64'd0);
        for (int le = 0; le < 2; le++) begin
            for (int z = 0; z < 2; z++) begin
                for (int di = 0; di < 5; di++) begin
                    for (int dl0 = 0; dl0 < 3; dl0++) begin
                        logic [63:0] b;
                        b = (di == 0 && dl0 == 0) ? 64'hFFFF_FFFF_FFFF_FFF8 : next_rand();
                        run_one(b, z[0], dl[di], next_rand(), next_rand(), le[0],
                                dl0, (dl0 + 1) % 3);
                    end
                end
            end
            run_bad(le[0]);
        end
        run_one(64'h0000_0000_0000_1000, 1'b0, 14'h0004,
                64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF, 1'b1, 1, 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule